// File: doc/BRIEF.md
# Stall-Driven Master/Filler Mode Controller

This block sequences a latency-critical core between two operating modes. In master mode a single latency-sensitive thread owns the pipeline and runs out of order. When that thread hits a stall of microsecond scale, the controller moves the core into filler mode. In filler mode a few borrowed batch threads run in order until the stall clears. The controller then drains the filler work and hands the pipeline back to the master thread.

The master thread's private state is never duplicated or disturbed. While filler threads run, the block holds writes off the master's architectural register region and lends the rest of the physical register file to the filler contexts as their architectural registers. It steers filler memory traffic through a small local L0 toward the neighbouring core's L1 caches, and it selects the spare TLB and branch-predictor copies. The number of filler contexts is computed when a stall is accepted: the free register space is divided by the per-context register count requested on `ctx_regs`, and the result is clamped to the number of hardware contexts.

A `busy` output is high during both transitions so that fetch is held off. A stall event that arrives while a transition or a filler episode is under way is dropped.

Top module: `stall_fill_ctrl`

## Requirements
- R1: After reset the core is in master mode: `mode_filler`, `busy`, `route_l0`, `xlate_sel`, `bp_sel`, `mrf_hold` are 0 and `ctx_en` is all zeros.
- R2: A `stall_start` seen in master mode starts the entry transition on the next cycle: `busy` goes to 1 while `mode_filler` and the four filler-side selects stay 0.
- R3: The entry transition lasts until a cycle with `pipe_empty` = 1. On the next cycle `mode_filler` = 1, `busy` = 0, and all four filler-side selects are 1.
- R4: If `stall_done` is seen at any point during the entry transition, the transition ends in master mode when `pipe_empty` arrives, and filler mode is never entered.
- R5: A `stall_done` in filler mode starts the drain transition on the next cycle: `mode_filler` = 0, `busy` = 1, `ctx_en` = 0, and the four filler-side selects stay 1.
- R6: The drain transition holds until a cycle with `pipe_empty` = 1. On the next cycle the core is back in master mode, with all outputs as in R1.
- R7: `stall_start` has no effect during the entry transition, filler mode or the drain transition, and `stall_done` has no effect in master mode.
- R8: The filler context count is latched when a stall is accepted. It equals min(MAX_CTX, floor((PHYS_REGS - ARCH_REGS) / `ctx_regs`)), and it is 0 when `ctx_regs` = 0. In filler mode `ctx_en` has exactly that many bits set, starting at bit 0, and a change of `ctx_regs` after acceptance has no effect.
- R9: `route_l0`, `xlate_sel`, `bp_sel` and `mrf_hold` are always equal. They are 1 exactly in filler mode and in the drain transition.
- R10: `busy` and `mode_filler` are never 1 together. `ctx_en` is all zeros whenever `mode_filler` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_start | input | 1 | Master thread has entered a microsecond-scale stall |
| stall_done | input | 1 | The master thread's stall has resolved |
| pipe_empty | input | 1 | No instructions of the outgoing mode remain in flight |
| ctx_regs | input | $clog2(PHYS_REGS+1) | Architectural registers needed per filler context |
| mode_filler | output | 1 | Filler mode: borrowed threads, in-order issue |
| busy | output | 1 | Transition in progress; hold fetch |
| route_l0 | output | 1 | Route I/D accesses through the L0 to the neighbour's L1 |
| xlate_sel | output | 1 | Select the filler TLB copy |
| bp_sel | output | 1 | Select the filler branch-predictor copy |
| mrf_hold | output | 1 | Protect the master's architectural register region |
| ctx_en | output | MAX_CTX | Enabled filler contexts, one bit each |

## Verification
Every cycle, the assertions check the transition edges of the state machine, the fact that a drain cannot end without `pipe_empty`, the exclusion between `busy` and filler mode, the population count of `ctx_en` against the latched count, and the rule that filler mode is only ever entered or left through a busy phase. Other behaviours can only be shown by the bench's scenarios. These are the arithmetic of the context count over every `ctx_regs` value, the latching of that count against later changes, the early-resolution path that skips filler mode, and the dropping of stray stall events in each state.

// File: rtl/stf_pkg.sv
package stf_pkg;
  typedef enum logic [1:0] {
    ST_MASTER = 2'd0,
    ST_ENTER  = 2'd1,
    ST_FILL   = 2'd2,
    ST_DRAIN  = 2'd3
  } stf_state_t;
endpackage

// File: rtl/stf_fsm.sv
module stf_fsm
  import stf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stall_start,
  input  logic       stall_done,
  input  logic       pipe_empty,
  output stf_state_t state_q,
  output logic       accept
);
  stf_state_t state_d;
  logic       pend_q, pend_d, pend_en;

  // pending-resolution flag only moves during the entry transition
  assign pend_en = (state_q == ST_ENTER);
  assign accept  = (state_q == ST_MASTER) && stall_start;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    case (state_q)
      ST_MASTER: begin
        if (stall_start) state_d = ST_ENTER;
      end
      ST_ENTER: begin
        if (pipe_empty) begin
          state_d = (pend_q || stall_done) ? ST_MASTER : ST_FILL;
          pend_d  = 1'b0;
        end else if (stall_done) begin
          pend_d  = 1'b1;
        end
      end
      ST_FILL: begin
        if (stall_done) state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (pipe_empty) state_d = ST_MASTER;
      end
      default: state_d = ST_MASTER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_MASTER;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MASTER && stall_start) |=> (state_q == ST_ENTER));

  assert_early_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ENTER && pipe_empty && (pend_q || stall_done)) |=> (state_q == ST_MASTER));

  assert_drain_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && stall_done) |=> (state_q == ST_DRAIN));

  assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN && !pipe_empty) |=> (state_q == ST_DRAIN));

  assert_fill_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && !stall_done) |=> (state_q == ST_FILL));
endmodule

// File: rtl/ctx_fit_calc.sv
module ctx_fit_calc #(
  parameter int PHYS_REGS = 64,
  parameter int ARCH_REGS = 16,
  parameter int MAX_CTX   = 4,
  localparam int RPW      = $clog2(PHYS_REGS + 1),
  localparam int CW       = $clog2(MAX_CTX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [RPW-1:0] ctx_regs,
  output logic [CW-1:0]  cnt_q
);
  localparam int FREE = PHYS_REGS - ARCH_REGS;

  logic [MAX_CTX-1:0] fits;
  logic [CW-1:0]      cnt_d;

  // k contexts fit when k times the per-context need stays within free space
  for (genvar k = 1; k <= MAX_CTX; k++) begin : g_fit
    assign fits[k-1] = (ctx_regs != '0) &&
                       ((32'(k) * 32'(ctx_regs)) <= 32'(FREE));
  end

  always_comb cnt_d = CW'($countones(fits));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= cnt_d;
  end

  assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cnt_q));

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (32'(cnt_q) <= 32'(MAX_CTX)));
endmodule

// File: rtl/stf_out_dec.sv
module stf_out_dec
  import stf_pkg::*;
#(
  parameter int MAX_CTX = 4,
  localparam int CW     = $clog2(MAX_CTX + 1)
) (
  input  stf_state_t         state_q,
  input  logic [CW-1:0]      cnt_q,
  output logic               mode_filler,
  output logic               busy,
  output logic               filler_side,
  output logic [MAX_CTX-1:0] ctx_en
);
  assign mode_filler = (state_q == ST_FILL);
  assign busy        = (state_q == ST_ENTER) || (state_q == ST_DRAIN);
  // filler-owned structures stay selected until the drain finishes
  assign filler_side = (state_q == ST_FILL) || (state_q == ST_DRAIN);

  for (genvar i = 0; i < MAX_CTX; i++) begin : g_ctx
    assign ctx_en[i] = mode_filler && (32'(i) < 32'(cnt_q));
  end
endmodule

// File: rtl/stall_fill_ctrl.sv
module stall_fill_ctrl
  import stf_pkg::*;
#(
  parameter int PHYS_REGS = 64,
  parameter int ARCH_REGS = 16,
  parameter int MAX_CTX   = 4,
  localparam int RPW      = $clog2(PHYS_REGS + 1),
  localparam int CW       = $clog2(MAX_CTX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall_start,
  input  logic               stall_done,
  input  logic               pipe_empty,
  input  logic [RPW-1:0]     ctx_regs,
  output logic               mode_filler,
  output logic               busy,
  output logic               route_l0,
  output logic               xlate_sel,
  output logic               bp_sel,
  output logic               mrf_hold,
  output logic [MAX_CTX-1:0] ctx_en
);
  stf_state_t    state_q;
  logic          accept;
  logic [CW-1:0] cnt_q;
  logic          filler_side;

  stf_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_start (stall_start),
    .stall_done  (stall_done),
    .pipe_empty  (pipe_empty),
    .state_q     (state_q),
    .accept      (accept)
  );

  ctx_fit_calc #(
    .PHYS_REGS (PHYS_REGS),
    .ARCH_REGS (ARCH_REGS),
    .MAX_CTX   (MAX_CTX)
  ) u_fit (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .ctx_regs (ctx_regs),
    .cnt_q    (cnt_q)
  );

  stf_out_dec #(
    .MAX_CTX (MAX_CTX)
  ) u_dec (
    .state_q     (state_q),
    .cnt_q       (cnt_q),
    .mode_filler (mode_filler),
    .busy        (busy),
    .filler_side (filler_side),
    .ctx_en      (ctx_en)
  );

  assign route_l0  = filler_side;
  assign xlate_sel = filler_side;
  assign bp_sel    = filler_side;
  assign mrf_hold  = filler_side;

  assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && mode_filler));

  assert_ctx_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_filler |-> (ctx_en == '0));

  assert_ctx_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_filler |-> ($countones(ctx_en) == 32'(cnt_q)));

  assert_fill_via_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_filler) |-> $past(busy));

  assert_release_via_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mrf_hold) |-> $past(busy));
endmodule

// File: tb/stall_fill_ctrl_tb_top.sv
`timescale 1ns/1ps
module stall_fill_ctrl_tb_top;
  localparam int PHYS = 64;
  localparam int ARCH = 16;
  localparam int MAXC = 4;
  localparam int RPW  = $clog2(PHYS + 1);

  logic clk, rst_n, stall_start, stall_done, pipe_empty;
  logic [RPW-1:0] ctx_regs;
  logic mode_filler, busy, route_l0, xlate_sel, bp_sel, mrf_hold;
  logic [MAXC-1:0] ctx_en;

  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  stall_fill_ctrl #(.PHYS_REGS(PHYS), .ARCH_REGS(ARCH), .MAX_CTX(MAXC)) dut_i (
    .clk(clk), .rst_n(rst_n), .stall_start(stall_start), .stall_done(stall_done),
    .pipe_empty(pipe_empty), .ctx_regs(ctx_regs), .mode_filler(mode_filler),
    .busy(busy), .route_l0(route_l0), .xlate_sel(xlate_sel), .bp_sel(bp_sel),
    .mrf_hold(mrf_hold), .ctx_en(ctx_en)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic int fit_n(int r);
    int n;
    if (r == 0) return 0;
    n = (PHYS - ARCH) / r;
    return (n > MAXC) ? MAXC : n;
  endfunction

  function automatic logic [MAXC-1:0] mask_of(int n);
    return MAXC'((1 << n) - 1);
  endfunction

  // drive for one clock edge, then sample 1 ns after it
  task automatic apply(input logic s, input logic d, input logic e);
    stall_start = s; stall_done = d; pipe_empty = e;
    @(posedge clk); #1;
    stall_start = 0; stall_done = 0; pipe_empty = 0;
  endtask

  task automatic expect_out(input string tag, input logic m, input logic b,
                            input logic side, input logic [MAXC-1:0] ce);
    logic [3:0] sel;
    sel = {route_l0, xlate_sel, bp_sel, mrf_hold};
    checks++;
    if (mode_filler !== m || busy !== b || sel !== {4{side}} || ctx_en !== ce) begin
      errors++;
      $display("FAIL %s: got mode=%b busy=%b sel=%b ctx=%b, expected mode=%b busy=%b sel=%b ctx=%b",
               tag, mode_filler, busy, sel, ctx_en, m, b, {4{side}}, ce);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; stall_start = 0; stall_done = 0; pipe_empty = 0; ctx_regs = RPW'(ARCH);
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1 in reset", 0, 0, 0, '0);
    rst_n = 1;
    @(posedge clk); #1;
    expect_out("R1 after reset", 0, 0, 0, '0);

    apply(0, 1, 1);
    expect_out("R7 stall_done ignored in master", 0, 0, 0, '0);

    // full episode with slow pipeline drains, ctx_regs=16 -> 3 contexts
    apply(1, 0, 0);
    expect_out("R2 entry begins", 0, 1, 0, '0);
    apply(1, 0, 0);
    expect_out("R7 start ignored during entry", 0, 1, 0, '0);
    apply(0, 0, 1);
    expect_out("R3 filler mode entered", 1, 0, 1, mask_of(fit_n(16)));
    apply(1, 0, 1);
    expect_out("R7 start ignored in filler", 1, 0, 1, mask_of(fit_n(16)));
    apply(0, 1, 0);
    expect_out("R5 drain begins", 0, 1, 1, '0);
    apply(1, 0, 0);
    expect_out("R6 R7 drain holds", 0, 1, 1, '0);
    apply(0, 0, 1);
    expect_out("R6 back to master", 0, 0, 0, '0);

    // early resolution recorded before pipe empties
    apply(1, 0, 0);
    expect_out("R2 entry again", 0, 1, 0, '0);
    apply(0, 1, 0);
    expect_out("R4 resolved mid-entry, still busy", 0, 1, 0, '0);
    apply(0, 0, 1);
    expect_out("R4 returns to master directly", 0, 0, 0, '0);

    // resolution in the same cycle as pipe_empty
    apply(1, 0, 1);
    expect_out("R2 entry with empty pipe", 0, 1, 0, '0);
    apply(0, 1, 1);
    expect_out("R4 same-cycle resolution", 0, 0, 0, '0);

    // sweep every ctx_regs value; change input after acceptance
    for (int r = 0; r < (1 << RPW); r++) begin
      ctx_regs = RPW'(r);
      apply(1, 0, 0);
      expect_out($sformatf("R2 sweep entry r=%0d", r), 0, 1, 0, '0);
      ctx_regs = RPW'(r ^ 5);
      apply(0, 0, 1);
      expect_out($sformatf("R8 context count r=%0d", r), 1, 0, 1, mask_of(fit_n(r)));
      ctx_regs = RPW'(1);
      apply(0, 0, 0);
      expect_out($sformatf("R8 count latched r=%0d", r), 1, 0, 1, mask_of(fit_n(r)));
      apply(0, 1, 1);
      expect_out($sformatf("R5 R9 drain r=%0d", r), 0, 1, 1, '0);
      apply(0, 0, 1);
      expect_out($sformatf("R6 R10 master r=%0d", r), 0, 0, 0, '0);
    end

    done_run = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule